// File: doc/BRIEF.md
# System Clock Stability Supervisor

This block decides when the on-chip system clock can be trusted. Software programs the clock period in femtoseconds. The block turns that period into a millisecond time base by accumulating femtoseconds each cycle. A programmable countdown, in milliseconds, then decides when the clock counts as stable. The countdown starts at one of two moments. With the clock PLL enabled, it starts when the external lock detector reports lock. With the PLL disabled, it starts on the very clock edge that disables it, and lock is ignored. A zero count means the clock is declared stable at once.

A VCO calibration is requested by setting a control bit and then clearing it. The clear launches a one-cycle request to the external calibration engine and raises a busy status until the engine answers with a done pulse. Losing lock, launching a calibration or changing the PLL mode drops the stable status and restarts the sequence.

The stable status directly gates the enable of the reference-input monitors. Rising edges of the two status bits can each raise a sticky interrupt flag through a mask.

Register access uses a plain write strobe with a combinational read. The register addresses are:

| Address | Contents |
|---|---|
| 0 | control: bit 0 PLL enable, bit 1 calibrate |
| 1 | period in fs |
| 2 | countdown value in ms |
| 3 | status, read only: bit 0 calibration busy, bit 1 stable |
| 4 | interrupt mask, same bit positions as status |
| 5 | interrupt flags, same bit positions, write one to clear |

Top module: `sysclk_stab_sup`

## Requirements
- R1: After reset, all of these are 0: `clk_stable`, `ref_mon_en`, `cal_busy`, `cal_req` and `irq`. The control register reads 1 (PLL enabled, calibrate bit clear), and period, countdown, mask and flags read 0.
- R2: The millisecond tick comes from an accumulator. Each cycle it adds the period register. When the sum reaches UNIT_FS (10^12 fs by default), it emits a tick and subtracts UNIT_FS. A countdown of N therefore spans ceil(N*UNIT_FS/period) cycles, counted from the accumulator clear at the start edge.
- R3: With the PLL enabled, the block waits for the timing start. The countdown starts on the first clock edge that samples `pll_lock` high while no calibration is busy. `clk_stable` rises after edge start+ceil(N*UNIT_FS/period)+1.
- R4: If the countdown value is 0 when timing starts, `clk_stable` is high right after the start edge.
- R5: Writing 0 to control bit 0 while it is 1 starts the countdown on that same write edge. While the PLL is disabled, `pll_lock` changes neither the countdown nor the stable status.
- R6: Any of these clears `clk_stable` at the next edge and returns the block to waiting for a timing start: a fall of `pll_lock` while the PLL is enabled, a calibration launch, or a change of control bit 0.
- R7: Writing 1 to control bit 1 requests nothing. Writing 0 to it while it is 1 launches a calibration: `cal_req` is high for exactly the one cycle after that write edge, and `cal_busy` rises at that edge. `cal_busy` falls on the edge that samples `cal_done` high.
- R8: A write to the countdown register during a running countdown leaves that countdown's length unchanged. The new value is used at the next timing start.
- R9: A rising edge of a status bit sets the flag in the same bit position if its mask bit is 1. A masked edge sets nothing. Writing 1 to a flag clears it. `irq` is the OR of the flags.
- R10: `ref_mon_en` stays low until `clk_stable` is high and follows it afterwards.
- R11: Period, countdown and mask registers read back what was written. Status reads bit 0 as calibration busy and bit 1 as stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pll_lock | input | 1 | Lock indication from the clock PLL |
| cal_done | input | 1 | Completion pulse from the calibration engine |
| cal_req | output | 1 | One-cycle calibration request |
| cal_busy | output | 1 | Calibration in progress |
| clk_stable | output | 1 | Countdown expired, clock trusted |
| ref_mon_en | output | 1 | Enable for the reference-input monitors |
| irq | output | 1 | Interrupt, OR of the sticky flags |

## Verification
The bench measures the exact cycle count from each timing start to `clk_stable` for several countdown values. An off-by-one in the accumulator compare or a stale tick left over from before the start would shift that count by a cycle.

It starts timing through each route: lock while enabled, the disable write itself, and lock after a calibration completes. A design that waits for lock in disabled mode, or one that starts while calibration is still busy, would miss the expected edge.

It rewrites the countdown mid-run, which catches a design that loads the count continuously. It toggles lock in disabled mode, which catches a design that restarts on lock loss when it should not.

For interrupts, it checks that only unmasked rising edges set flags and that write-one clears them. For calibration, it checks that setting the bit alone launches nothing.

// File: rtl/sysclk_sup_pkg.sv
package sysclk_sup_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } stab_state_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_TIMER  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_CAL = 1;

  localparam int ST_BITS = 2;
  localparam int SB_CAL  = 0;
  localparam int SB_STB  = 1;

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int     PERIOD_W = 21,
  parameter int     ACC_W    = 41,
  parameter longint UNIT_FS  = 64'd1000000000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);

  localparam logic [ACC_W-1:0] UNIT = ACC_W'(UNIT_FS);

  // Returns {wrapped, next accumulator value}.
  function automatic logic [ACC_W:0] acc_step(input logic [ACC_W-1:0] acc,
                                              input logic [PERIOD_W-1:0] per);
    logic [ACC_W-1:0] sum;
    sum = acc + ACC_W'(per);
    if (sum >= UNIT) acc_step = {1'b1, sum - UNIT};
    else             acc_step = {1'b0, sum};
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   step;

  assign step = acc_step(acc_q, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (clr) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= step[ACC_W-1:0];
      tick  <= step[ACC_W];
    end
  end

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q < UNIT && ACC_W'(period) < UNIT) |=> acc_q < UNIT);

endmodule

// File: rtl/stab_countdown.sv
module stab_countdown
  import sysclk_sup_pkg::*;
#(
  parameter int TIMER_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               dis_now,
  input  logic               pll_en,
  input  logic               pll_lock,
  input  logic               cal_busy,
  input  logic               tick,
  input  logic [TIMER_W-1:0] load,
  output logic               start,
  output logic               stable
);

  stab_state_e        state_q;
  logic [TIMER_W-1:0] cnt_q;
  logic               wait_go;

  assign wait_go = (state_q == ST_WAIT) && !restart &&
                   (!pll_en || (pll_lock && !cal_busy));
  assign start   = dis_now || wait_go;
  assign stable  = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
    end else if (start) begin
      cnt_q   <= load;
      state_q <= (load == '0) ? ST_DONE : ST_RUN;
    end else if (restart) begin
      state_q <= ST_WAIT;
    end else if (state_q == ST_RUN && tick) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == TIMER_W'(1)) state_q <= ST_DONE;
    end
  end

  // R4
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && load == '0) |=> stable);

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !start && !restart) |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic cal_wbit,
  input  logic cal_done,
  output logic cal_bit,
  output logic launch,
  output logic cal_req,
  output logic cal_busy
);

  assign launch = ctrl_wr && cal_bit && !cal_wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_bit  <= 1'b0;
      cal_req  <= 1'b0;
      cal_busy <= 1'b0;
    end else begin
      if (ctrl_wr) cal_bit <= cal_wbit;
      cal_req <= launch;
      if (launch)        cal_busy <= 1'b1;
      else if (cal_done) cal_busy <= 1'b0;
    end
  end

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |=> !cal_req);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !cal_done) |=> cal_busy);

endmodule

// File: rtl/sysclk_stab_sup.sv
module sysclk_stab_sup
  import sysclk_sup_pkg::*;
#(
  parameter int     PERIOD_W = 21,
  parameter int     TIMER_W  = 20,
  parameter int     ACC_W    = 41,
  parameter int     DATA_W   = 32,
  parameter longint UNIT_FS  = 64'd1000000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pll_lock,
  input  logic              cal_done,
  output logic              cal_req,
  output logic              cal_busy,
  output logic              clk_stable,
  output logic              ref_mon_en,
  output logic              irq
);

  logic                pll_en_q;
  logic [PERIOD_W-1:0] period_q;
  logic [TIMER_W-1:0]  timer_q;
  logic [ST_BITS-1:0]  mask_q, flag_q, prev_q, status, rise;
  logic                lock_d;

  logic ctrl_wr, en_change, dis_now, lock_fall, restart;
  logic cal_bit, cal_launch, tick, start;

  assign ctrl_wr   = reg_we && (reg_addr == A_CTRL);
  assign en_change = ctrl_wr && (reg_wdata[CTRL_EN] != pll_en_q);
  assign dis_now   = en_change && !reg_wdata[CTRL_EN];
  assign lock_fall = pll_en_q && lock_d && !pll_lock;
  assign restart   = cal_launch || en_change || lock_fall;

  cal_sequencer u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (ctrl_wr),
    .cal_wbit (reg_wdata[CTRL_CAL]),
    .cal_done (cal_done),
    .cal_bit  (cal_bit),
    .launch   (cal_launch),
    .cal_req  (cal_req),
    .cal_busy (cal_busy)
  );

  ms_tick_gen #(
    .PERIOD_W (PERIOD_W),
    .ACC_W    (ACC_W),
    .UNIT_FS  (UNIT_FS)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start),
    .period (period_q),
    .tick   (tick)
  );

  stab_countdown #(
    .TIMER_W (TIMER_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .dis_now  (dis_now),
    .pll_en   (pll_en_q),
    .pll_lock (pll_lock),
    .cal_busy (cal_busy),
    .tick     (tick),
    .load     (timer_q),
    .start    (start),
    .stable   (clk_stable)
  );

  assign ref_mon_en = clk_stable;

  always_comb begin
    status         = '0;
    status[SB_CAL] = cal_busy;
    status[SB_STB] = clk_stable;
  end
  assign rise = status & ~prev_q;
  assign irq  = |flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_en_q <= 1'b1;
      period_q <= '0;
      timer_q  <= '0;
      mask_q   <= '0;
      flag_q   <= '0;
      prev_q   <= '0;
      lock_d   <= 1'b0;
    end else begin
      lock_d <= pll_lock;
      prev_q <= status;
      if (ctrl_wr) pll_en_q <= reg_wdata[CTRL_EN];
      if (reg_we && reg_addr == A_PERIOD) period_q <= reg_wdata[PERIOD_W-1:0];
      if (reg_we && reg_addr == A_TIMER)  timer_q  <= reg_wdata[TIMER_W-1:0];
      if (reg_we && reg_addr == A_MASK)   mask_q   <= reg_wdata[ST_BITS-1:0];
      if (reg_we && reg_addr == A_FLAGS)
        flag_q <= (flag_q & ~reg_wdata[ST_BITS-1:0]) | (rise & mask_q);
      else
        flag_q <= flag_q | (rise & mask_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_EN]  = pll_en_q;
        reg_rdata[CTRL_CAL] = cal_bit;
      end
      A_PERIOD: reg_rdata = DATA_W'(period_q);
      A_TIMER:  reg_rdata = DATA_W'(timer_q);
      A_STATUS: reg_rdata = DATA_W'(status);
      A_MASK:   reg_rdata = DATA_W'(mask_q);
      A_FLAGS:  reg_rdata = DATA_W'(flag_q);
      default:  reg_rdata = '0;
    endcase
  end

  // R6
  lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_fall && !dis_now) |=> !clk_stable);

  // R6
  cal_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_launch && !dis_now) |=> !clk_stable);

  // R9
  stb_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stable && !prev_q[SB_STB] && mask_q[SB_STB]) |=> irq);

  // R5
  dis_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en_q && !restart && clk_stable) |=> clk_stable);

endmodule

// File: tb/tb_sysclk_stab_sup.sv
module tb_sysclk_stab_sup;
  import sysclk_sup_pkg::*;

  localparam longint UNIT = 64'd1000;
  localparam int     PER  = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pll_lock = 1'b0;
  logic        cal_done = 1'b0;
  logic        cal_req, cal_busy, clk_stable, ref_mon_en, irq;

  int checks = 0;
  int failures = 0;

  typedef struct { string req; int val; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  sysclk_stab_sup #(.UNIT_FS(UNIT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_lock(pll_lock),
    .cal_done(cal_done), .cal_req(cal_req), .cal_busy(cal_busy),
    .clk_stable(clk_stable), .ref_mon_en(ref_mon_en), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int d);
    @(negedge clk);
    reg_addr = a;
    #1 d = int'(reg_rdata);
  endtask

  // Cycles from start edge to stable: ceil(N*UNIT/PER) ticks plus two samples.
  function automatic int lat(int n);
    if (n == 0) return 1;
    return int'((longint'(n) * UNIT + PER - 1) / PER) + 2;
  endfunction

  // Driver side of the scoreboard.
  task automatic expect_lat(string req, int n);
    exp_t e;
    e.req = req; e.val = lat(n);
    exp_q.push_back(e);
  endtask

  // Monitor side: count samples until stable, then compare with the queue head.
  task automatic monitor_lat();
    int n;
    bit done;
    exp_t e;
    n = 0; done = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (clk_stable || n >= 600) done = 1;
      else @(posedge clk);
    end
    e = exp_q.pop_front();
    chk(e.req, n, e.val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 stable", clk_stable, 0);
    chk("R1 ref_mon_en", ref_mon_en, 0);
    chk("R1 cal_busy", cal_busy, 0);
    chk("R1 cal_req", cal_req, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    rd(A_CTRL, d);   chk("R1 ctrl", d, 1);
    rd(A_PERIOD, d); chk("R1 period", d, 0);
    rd(A_TIMER, d);  chk("R1 timer", d, 0);
    rd(A_FLAGS, d);  chk("R1 flags", d, 0);

    wr(A_PERIOD, PER);
    wr(A_TIMER, 3);
    wr(A_MASK, 3);
    rd(A_PERIOD, d); chk("R11 period", d, PER);
    rd(A_TIMER, d);  chk("R11 timer", d, 3);
    rd(A_MASK, d);   chk("R11 mask", d, 3);
    // R3: waits for lock
    repeat (20) @(posedge clk);
    #1 chk("R3 no lock", clk_stable, 0);

    // R2 R3: lock starts countdown of 3 ms
    @(negedge clk); pll_lock = 1'b1;
    @(posedge clk);
    expect_lat("R3 lock latency", 3);
    monitor_lat();
    chk("R10 ref_mon_en", ref_mon_en, 1);
    rd(A_STATUS, d); chk("R11 status", d, 2);
    @(negedge clk); chk("R9 irq stable", irq, 1);
    rd(A_FLAGS, d); chk("R9 flags", d, 2);
    wr(A_FLAGS, 2);
    @(negedge clk); chk("R9 w1c", irq, 0);

    // R6: lock loss
    @(negedge clk); pll_lock = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R6 lock loss", clk_stable, 0);
    chk("R10 off", ref_mon_en, 0);

    // R8: countdown write mid-run has no effect on this run
    @(negedge clk); pll_lock = 1'b1;
    @(posedge clk);
    expect_lat("R8 running unchanged", 3);
    fork
      monitor_lat();
      begin repeat (3) @(posedge clk); wr(A_TIMER, 20); end
    join
    rd(A_TIMER, d); chk("R8 readback", d, 20);

    // R5: disable starts at the write edge, lock ignored
    wr(A_CTRL, 0);
    expect_lat("R5 disable latency", 20);
    fork
      monitor_lat();
      begin
        @(negedge clk); pll_lock = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk); pll_lock = 1'b1;
      end
    join
    @(negedge clk); pll_lock = 1'b0;
    repeat (4) @(posedge clk);
    #1 chk("R5 lock ignored", clk_stable, 1);

    // R4: zero count
    wr(A_TIMER, 0);
    wr(A_CTRL, 1);
    @(negedge clk); chk("R6 enable change", clk_stable, 0);
    repeat (10) @(posedge clk);
    #1 chk("R3 wait lock", clk_stable, 0);
    @(negedge clk); pll_lock = 1'b1;
    @(posedge clk);
    expect_lat("R4 zero", 0);
    monitor_lat();
    wr(A_FLAGS, 3);

    // R7: set alone requests nothing
    wr(A_CTRL, 3);
    @(negedge clk);
    chk("R7 set no req", cal_req, 0);
    chk("R7 set no busy", cal_busy, 0);
    chk("R7 set keeps stable", clk_stable, 1);
    wr(A_TIMER, 1);
    wr(A_CTRL, 1);
    @(negedge clk);
    chk("R7 req pulse", cal_req, 1);
    chk("R7 busy", cal_busy, 1);
    chk("R6 cal clears stable", clk_stable, 0);
    @(negedge clk);
    chk("R7 req one cycle", cal_req, 0);
    chk("R9 cal irq", irq, 1);
    rd(A_FLAGS, d); chk("R9 cal flag", d, 1);
    wr(A_FLAGS, 1);
    repeat (10) @(posedge clk);
    #1 chk("R3 busy blocks", clk_stable, 0);
    @(negedge clk); cal_done = 1'b1;
    @(posedge clk);
    #1 cal_done = 1'b0;
    chk("R7 done clears busy", cal_busy, 0);
    @(posedge clk);
    expect_lat("R3 after cal", 1);
    monitor_lat();

    // R9: masked edge sets nothing
    wr(A_MASK, 0);
    wr(A_FLAGS, 3);
    @(negedge clk); pll_lock = 1'b0;
    @(posedge clk);
    @(negedge clk); pll_lock = 1'b1;
    @(posedge clk);
    expect_lat("R2 one ms", 1);
    monitor_lat();
    @(negedge clk); chk("R9 masked irq", irq, 0);
    rd(A_FLAGS, d); chk("R9 masked flags", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule